// File: doc/BRIEF.md
# Indexed Pixel Colour Path with Cursor Overlay

This block sits in the scan-out path of a display controller. On each valid strobe it takes one pixel of 8-bit palette index together with its raster coordinates, and it returns the 24-bit RGB value that goes to the screen. Most pixels are looked up in a 256-entry colour palette. A 64x64 hardware cursor can be laid over them. The cursor shape is a two-bit-per-pixel pattern. Code zero lets the palette colour through, and the other three codes pick one of three cursor colours.

The colour palette and the cursor pattern live in synchronous RAMs outside the block. The block drives their read addresses from the current input in the same cycle, and their data returns one cycle later. The three cursor colours arrive as a flat input bus that the parent holds in registers. A cursor-disable input removes the cursor, and a blank input forces the output to black. The result is registered and leaves the block two cycles after its input.

Top module: `pix_cursor_overlay`

## Requirements
- R1: `rgb_valid_o` equals `pix_valid_i` delayed by exactly two clock cycles. `rgb_o` changes only when a valid pixel reaches the output and holds its value between pixels.
- R2: A pixel is inside the cursor when cursor_x <= X < cursor_x + 64 and cursor_y <= Y < cursor_y + 64. The sums are formed one bit wider than the coordinates, so a cursor near coordinate 4095 never wraps round to small X or Y.
- R3: In the cycle a pixel is presented, `pat_addr_o` equals (Y - cursor_y) * 8 + (X - cursor_x) / 8 for a pixel inside the cursor, and `pal_addr_o` equals `pix_index_i`.
- R4: The cursor code is bits [2k+1:2k] of the 16-bit pattern word, where k = (X - cursor_x) mod 8.
- R5: Inside the cursor, code 0 shows the colour palette entry for the pixel's index. Codes 1, 2 and 3 show cursor colours 0, 1 and 2, where cursor colour n is `cur_pal_i[24n+23:24n]`. All RGB values are packed red in [23:16], green in [15:8] and blue in [7:0].
- R6: While `curs_off_i` is 1, no pixel is inside the cursor, and every pixel shows its colour palette entry.
- R7: A pixel outside the cursor shows the colour palette entry for its index, `pal_data_i`, as returned for that pixel.
- R8: A pixel presented with `blank_i` at 1 comes out as 24'h000000, and its valid flag still goes out two cycles later.
- R9: While reset is held, and after it is released until the first pixel arrives, `rgb_o` is 0 and `rgb_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel strobe |
| pix_x_i | input | 12 | Raster X of the pixel |
| pix_y_i | input | 12 | Raster Y of the pixel |
| pix_index_i | input | 8 | Palette index fetched from VRAM |
| curs_x_i | input | 12 | Cursor left column |
| curs_y_i | input | 12 | Cursor top row |
| curs_off_i | input | 1 | Cursor disable |
| blank_i | input | 1 | Force output black |
| pal_addr_o | output | 8 | Colour palette read address |
| pal_data_i | input | 24 | Colour palette read data, one cycle after the address |
| pat_addr_o | output | 9 | Cursor pattern read address |
| pat_data_i | input | 16 | Cursor pattern read data, one cycle after the address |
| cur_pal_i | input | 72 | Three cursor colours, colour n at bits [24n+23:24n] |
| rgb_o | output | 24 | Registered output colour |
| rgb_valid_o | output | 1 | Output valid |

## Verification
The two read addresses are combinational from the inputs, so the bench checks them one time step after it drives a pixel, in that same cycle. The colour result and its valid flag pass two clock edges: the RAM read and the output register. The bench drives each pixel on a falling edge and compares `rgb_o` on the second falling edge after that. In a back-to-back burst it compares, on each falling edge, the output of the pixel driven two edges earlier. On the falling edge after the burst, the bench checks that the valid flag has dropped and that the colour has held.

// File: rtl/pco_pkg.sv
package pco_pkg;
  localparam int CURS_COLORS = 3;
  localparam int CODE_W      = 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_CLEAR = 2'd0,
    CODE_C0    = 2'd1,
    CODE_C1    = 2'd2,
    CODE_C2    = 2'd3
  } cur_code_e;
endpackage

// File: rtl/pco_axis_cmp.sv
module pco_axis_cmp #(
  parameter int COORD_W   = 12,
  parameter int CURS_SIZE = 64,
  localparam int OFS_W    = $clog2(CURS_SIZE)
) (
  input  logic [COORD_W-1:0] pos_i,
  input  logic [COORD_W-1:0] base_i,
  output logic               in_win_o,
  output logic [OFS_W-1:0]   ofs_o
);
  logic [COORD_W:0] diff;

  // one extra bit: a negative offset shows in the top bit, never wraps
  assign diff     = {1'b0, pos_i} - {1'b0, base_i};
  assign in_win_o = !diff[COORD_W] && (diff[COORD_W-1:0] < COORD_W'(CURS_SIZE));
  assign ofs_o    = diff[OFS_W-1:0];
endmodule

// File: rtl/pco_code_sel.sv
module pco_code_sel
  import pco_pkg::*;
#(
  parameter int PAT_W  = 16,
  parameter int RGB_W  = 24,
  localparam int SEL_W = $clog2(PAT_W / CODE_W)
) (
  input  logic [PAT_W-1:0]             word_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic                         hit_i,
  input  logic                         blank_i,
  input  logic [RGB_W-1:0]             pal_i,
  input  logic [CURS_COLORS*RGB_W-1:0] curpal_i,
  output logic [RGB_W-1:0]             rgb_o
);
  cur_code_e code;

  assign code = cur_code_e'(word_i[CODE_W*sel_i +: CODE_W]);

  always_comb begin
    if (blank_i)                         rgb_o = '0;
    else if (hit_i && code != CODE_CLEAR) rgb_o = curpal_i[(int'(code) - 1) * RGB_W +: RGB_W];
    else                                 rgb_o = pal_i;
  end
endmodule

// File: rtl/pix_cursor_overlay.sv
module pix_cursor_overlay
  import pco_pkg::*;
#(
  parameter int COORD_W   = 12,
  parameter int CURS_SIZE = 64,
  parameter int IDX_W     = 8,
  parameter int CHAN_W    = 8,
  parameter int PAT_W     = 16,
  localparam int RGB_W    = 3 * CHAN_W,
  localparam int OFS_W    = $clog2(CURS_SIZE),
  localparam int CPW      = PAT_W / CODE_W,
  localparam int SEL_W    = $clog2(CPW),
  localparam int COL_W    = $clog2(CURS_SIZE / CPW),
  localparam int PAT_AW   = OFS_W + COL_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         pix_valid_i,
  input  logic [COORD_W-1:0]           pix_x_i,
  input  logic [COORD_W-1:0]           pix_y_i,
  input  logic [IDX_W-1:0]             pix_index_i,
  input  logic [COORD_W-1:0]           curs_x_i,
  input  logic [COORD_W-1:0]           curs_y_i,
  input  logic                         curs_off_i,
  input  logic                         blank_i,
  output logic [IDX_W-1:0]             pal_addr_o,
  input  logic [RGB_W-1:0]             pal_data_i,
  output logic [PAT_AW-1:0]            pat_addr_o,
  input  logic [PAT_W-1:0]             pat_data_i,
  input  logic [CURS_COLORS*RGB_W-1:0] cur_pal_i,
  output logic [RGB_W-1:0]             rgb_o,
  output logic                         rgb_valid_o
);
  logic [COORD_W-1:0] pos_a  [2];
  logic [COORD_W-1:0] base_a [2];
  logic               in_a   [2];
  logic [OFS_W-1:0]   ofs_a  [2];

  assign pos_a[0]  = pix_x_i;
  assign pos_a[1]  = pix_y_i;
  assign base_a[0] = curs_x_i;
  assign base_a[1] = curs_y_i;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    pco_axis_cmp #(.COORD_W(COORD_W), .CURS_SIZE(CURS_SIZE)) u_cmp (
      .pos_i   (pos_a[a]),
      .base_i  (base_a[a]),
      .in_win_o(in_a[a]),
      .ofs_o   (ofs_a[a])
    );
  end

  logic hit_d;
  assign hit_d      = in_a[0] && in_a[1] && !curs_off_i;
  assign pat_addr_o = {ofs_a[1], ofs_a[0][OFS_W-1:SEL_W]};
  assign pal_addr_o = pix_index_i;

  // stage 1: aligned with RAM read data
  logic             v_q, hit_q, blank_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q     <= 1'b0;
      hit_q   <= 1'b0;
      blank_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      v_q     <= pix_valid_i;
      hit_q   <= hit_d;
      blank_q <= blank_i;
      sel_q   <= ofs_a[0][SEL_W-1:0];
    end
  end

  logic [RGB_W-1:0] rgb_d;

  pco_code_sel #(.PAT_W(PAT_W), .RGB_W(RGB_W)) u_sel (
    .word_i  (pat_data_i),
    .sel_i   (sel_q),
    .hit_i   (hit_q),
    .blank_i (blank_q),
    .pal_i   (pal_data_i),
    .curpal_i(cur_pal_i),
    .rgb_o   (rgb_d)
  );

  // stage 2: output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_o       <= '0;
      rgb_valid_o <= 1'b0;
    end else begin
      rgb_valid_o <= v_q;
      if (v_q) rgb_o <= rgb_d;
    end
  end
endmodule

// File: rtl/pco_checker.sv
module pco_checker #(
  parameter int COORD_W   = 12,
  parameter int CURS_SIZE = 64,
  parameter int RGB_W     = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pix_valid_i,
  input logic [COORD_W-1:0] pix_x_i,
  input logic [COORD_W-1:0] pix_y_i,
  input logic [COORD_W-1:0] curs_x_i,
  input logic [COORD_W-1:0] curs_y_i,
  input logic               curs_off_i,
  input logic               blank_i,
  input logic [RGB_W-1:0]   pal_data_i,
  input logic [RGB_W-1:0]   rgb_o,
  input logic               rgb_valid_o,
  input logic               hit_q
);
  localparam int EW = COORD_W + 1;

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  logic [EW-1:0] ex, ey, ecx, ecy;
  logic          ref_hit;
  assign ex  = {1'b0, pix_x_i};
  assign ey  = {1'b0, pix_y_i};
  assign ecx = {1'b0, curs_x_i};
  assign ecy = {1'b0, curs_y_i};
  assign ref_hit = !curs_off_i && ex >= ecx && ex < ecx + EW'(CURS_SIZE)
                                && ey >= ecy && ey < ecy + EW'(CURS_SIZE);

  assert_reset_R9: assert property (@(posedge clk_i) !rst_ni |=> !rgb_valid_o);

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q == 2'd2 |-> rgb_valid_o == $past(pix_valid_i, 2));

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q == 2'd2 && !$past(pix_valid_i, 2) |-> rgb_o == $past(rgb_o));

  assert_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q != 2'd0 |-> hit_q == $past(ref_hit));

  assert_cursor_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q != 2'd0 && $past(curs_off_i) |-> !hit_q);

  assert_outside_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q == 2'd2 && rgb_valid_o && !$past(hit_q) && !$past(blank_i, 2)
      |-> rgb_o == $past(pal_data_i));

  assert_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q == 2'd2 && $past(pix_valid_i, 2) && $past(blank_i, 2) |-> rgb_o == '0);
endmodule

bind pix_cursor_overlay pco_checker #(
  .COORD_W(COORD_W), .CURS_SIZE(CURS_SIZE), .RGB_W(RGB_W)
) u_chk (.*);

// File: tb/pix_cursor_overlay_bench.sv
module pix_cursor_overlay_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic [11:0] pix_x_i = '0, pix_y_i = '0;
  logic [7:0]  pix_index_i = '0;
  logic [11:0] curs_x_i = '0, curs_y_i = '0;
  logic        curs_off_i = 1'b0, blank_i = 1'b0;
  logic [7:0]  pal_addr_o;
  logic [23:0] pal_data_i;
  logic [8:0]  pat_addr_o;
  logic [15:0] pat_data_i;
  logic [71:0] cur_pal_i;
  logic [23:0] rgb_o;
  logic        rgb_valid_o;

  localparam logic [23:0] CC0 = 24'hFF0000, CC1 = 24'h00FF00, CC2 = 24'h0000FF;
  assign cur_pal_i = {CC2, CC1, CC0};

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  pix_cursor_overlay u_pix_cursor_overlay (.*);

  function automatic logic [23:0] pal_of(int i);
    logic [7:0] b = 8'(i);
    return {b, ~b, b + 8'h33};
  endfunction

  logic [15:0] pat_mem [512];
  always @(posedge clk_i) begin
    pal_data_i <= pal_of(int'(pal_addr_o));
    pat_data_i <= pat_mem[pat_addr_o];
  end

  int n_checks = 0, n_errors = 0;

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_rgb(int x, int y, int idx);
    int cx = int'(curs_x_i), cy = int'(curs_y_i), code;
    logic [15:0] w;
    if (blank_i) return 24'h0;
    if (curs_off_i || x < cx || x >= cx + 64 || y < cy || y >= cy + 64) return pal_of(idx);
    w = pat_mem[(y - cy) * 8 + (x - cx) / 8];
    code = int'((w >> (((x - cx) % 8) * 2)) & 16'h3);
    case (code)
      1: return CC0;
      2: return CC1;
      3: return CC2;
      default: return pal_of(idx);
    endcase
  endfunction

  task automatic drive(int x, int y, int idx);
    pix_x_i = 12'(x); pix_y_i = 12'(y); pix_index_i = 8'(idx); pix_valid_i = 1'b1;
  endtask

  task automatic send_chk(int x, int y, int idx, string rq);
    logic [23:0] e = expect_rgb(x, y, idx);
    @(negedge clk_i); drive(x, y, idx);
    @(negedge clk_i); pix_valid_i = 1'b0;
    @(negedge clk_i);
    check(rq, 32'(rgb_valid_o), 32'd1);
    check(rq, 32'(rgb_o), 32'(e));
  endtask

  task automatic test_reset();
    check("R9 valid", 32'(rgb_valid_o), 32'd0);
    check("R9 rgb", 32'(rgb_o), 32'd0);
  endtask

  task automatic test_outside();
    curs_x_i = 12'd100; curs_y_i = 12'd50;
    send_chk(10, 10, 8'h00, "R7 idx00");
    send_chk(500, 300, 8'hA7, "R7 idxA7");
    send_chk(99, 60, 8'hFF, "R7 left of cursor");
  endtask

  task automatic test_window();
    curs_x_i = 12'd100; curs_y_i = 12'd50;
    pat_mem[0]   = 16'h0003;   // first pixel code 3
    pat_mem[511] = 16'hC000;   // last pixel code 3
    pat_mem[8]   = 16'h0002;   // row 1, first pixel code 2
    send_chk(100, 50, 8'h11, "R2 top-left corner");
    check("R2 corner colour", 32'(rgb_o), 32'(CC2));
    send_chk(163, 113, 8'h12, "R2 bottom-right corner");
    check("R2 far corner colour", 32'(rgb_o), 32'(CC2));
    send_chk(164, 50, 8'h13, "R2 right edge excluded");
    check("R2 right excluded colour", 32'(rgb_o), 32'(pal_of(8'h13)));
    send_chk(100, 114, 8'h14, "R2 bottom edge excluded");
    send_chk(100, 49, 8'h15, "R2 above");
  endtask

  task automatic test_codes();
    curs_x_i = 12'd200; curs_y_i = 12'd20;
    pat_mem[0] = 16'h00E4;     // pixels 0..3 carry codes 0,1,2,3
    send_chk(200, 20, 8'h40, "R5 code0 transparent");
    check("R5 code0 palette", 32'(rgb_o), 32'(pal_of(8'h40)));
    send_chk(201, 20, 8'h41, "R5 code1 colour0");
    check("R4 code1", 32'(rgb_o), 32'(CC0));
    send_chk(202, 20, 8'h42, "R5 code2 colour1");
    check("R4 code2", 32'(rgb_o), 32'(CC1));
    send_chk(203, 20, 8'h43, "R5 code3 colour2");
    check("R4 code3", 32'(rgb_o), 32'(CC2));
    pat_mem[2] = 16'h8000;     // column 23: word 2, pair 7 = code 2
    send_chk(223, 20, 8'h44, "R4 high pair");
    check("R4 pair7", 32'(rgb_o), 32'(CC1));
  endtask

  task automatic test_addr();
    curs_x_i = 12'd300; curs_y_i = 12'd400;
    @(negedge clk_i); drive(321, 405, 8'h5C);
    #1;
    check("R3 pattern address", 32'(pat_addr_o), 32'd42);
    check("R3 palette address", 32'(pal_addr_o), 32'h5C);
    @(negedge clk_i); pix_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic test_cursor_off();
    curs_x_i = 12'd200; curs_y_i = 12'd20; pat_mem[0] = 16'h00E4;
    curs_off_i = 1'b1;
    send_chk(203, 20, 8'h66, "R6 cursor disabled");
    check("R6 palette colour", 32'(rgb_o), 32'(pal_of(8'h66)));
    curs_off_i = 1'b0;
  endtask

  task automatic test_blank();
    blank_i = 1'b1;
    send_chk(10, 10, 8'hA7, "R8 blank outside");
    curs_x_i = 12'd200; curs_y_i = 12'd20;
    send_chk(203, 20, 8'h01, "R8 blank over cursor");
    blank_i = 1'b0;
  endtask

  task automatic test_edge_wrap();
    curs_x_i = 12'd4090; curs_y_i = 12'd4090;
    pat_mem[0]  = 16'hFFFF;
    pat_mem[40] = 16'h0C00;    // row 5, pair 5 = code 3
    send_chk(5, 5, 8'h21, "R2 no wrap");
    check("R2 no wrap colour", 32'(rgb_o), 32'(pal_of(8'h21)));
    send_chk(4095, 4095, 8'h22, "R2 near max");
    check("R2 near max colour", 32'(rgb_o), 32'(CC2));
  endtask

  task automatic test_stream();
    logic [23:0] e0, e1, e2;
    curs_x_i = 12'd1000; curs_y_i = 12'd1000;
    e0 = pal_of(8'h01); e1 = pal_of(8'h02); e2 = pal_of(8'h03);
    @(negedge clk_i); drive(1, 1, 8'h01);
    @(negedge clk_i);
    check("R1 not yet valid", 32'(rgb_valid_o), 32'd0);
    drive(2, 1, 8'h02);
    @(negedge clk_i);
    check("R1 p0 valid", 32'(rgb_valid_o), 32'd1);
    check("R1 p0 rgb", 32'(rgb_o), 32'(e0));
    drive(3, 1, 8'h03);
    @(negedge clk_i);
    check("R1 p1 rgb", 32'(rgb_o), 32'(e1));
    pix_valid_i = 1'b0; pix_index_i = 8'h7E;
    @(negedge clk_i);
    check("R1 p2 rgb", 32'(rgb_o), 32'(e2));
    @(negedge clk_i);
    check("R1 valid dropped", 32'(rgb_valid_o), 32'd0);
    check("R1 rgb held", 32'(rgb_o), 32'(e2));
  endtask

  initial begin
    for (int a = 0; a < 512; a++) pat_mem[a] = 16'(a * 963) ^ 16'hA5A5;
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_outside();
    test_window();
    test_codes();
    test_addr();
    test_cursor_off();
    test_blank();
    test_edge_wrap();
    test_stream();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    n_errors++;
    n_checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule